// File: doc/BRIEF.md
# Serial Clock Synthesizer Loader

The loader sits behind a single register write port and collects a clock-synthesizer programming word that software sends one bit per write. Each accepted write shifts its data bit into a 56-bit history register. A write that also carries the end marker closes the frame. The last 56 bits received, including the bit on the marker write itself, are then decoded into parallel settings: a post-divider select, a frequency band select, and the M, A and R divider fields.

A frame passes a range check before it is accepted. If its M field exceeds the legal maximum, the frame is rejected, an error pulse is raised, and the outputs keep their previous settings. An accepted frame updates all outputs at once and raises a one-cycle valid strobe. Bits in the frame that carry no field (the preamble and the filler between fields) are ignored. Bits received before the last 56 are also ignored.

Top module: `synth_serial_loader`

## Requirements
- R1: After reset the outputs are M=34, A=1, R=29, post-divider code 0, band low (0), with valid_o=0 and err_o=0. The history register is cleared to all zeros.
- R2: Each cycle with wr_en_i=1 shifts wr_data_i[0] into the history register. Cycles with wr_en_i=0 shift nothing and latch nothing, whatever wr_data_i holds.
- R3: Frame bits are numbered by arrival, 0 oldest to 55 newest. Every field is sent LSB first. Post-divider code is at 12..13, band code at 24..25, M at 32..39, A at 40..47 and R at 48..55. All other positions are ignored.
- R4: An accepted write with wr_data_i[1]=1 is the last bit of the frame: its wr_data_i[0] is bit 7 of R, and it triggers decoding and the latch.
- R5: post_div_o gives log2 of the division ratio: code 0 gives 0 (divide by 1), code 1 gives 1 (divide by 2), and codes 2 and 3 give 2 (divide by 4).
- R6: band_o is 0 (low) for band code 00, 1 (middle) for code 01 (first bit sent is 1, second is 0), and 2 (high) for codes 10 and 11. It never reads 3.
- R7: A frame whose M exceeds 63 is rejected. err_o pulses for one cycle, valid_o stays 0, and all setting outputs keep their previous values.
- R8: An accepted frame drives all outputs to the new values and pulses valid_o for exactly one cycle, both in the cycle after the marker write. Outputs do not change in any cycle without valid_o.
- R9: Only the 56 most recent bits form the frame. Any number of earlier bits has no effect on the result.
- R10: After reset, a marker arriving after fewer than 56 bits treats the missing older bits as zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe for the clock register |
| wr_data_i | input | 2 | Bit 0 serial data, bit 1 end marker |
| post_div_o | output | 2 | Post-divider as log2 of the division ratio |
| band_o | output | 2 | Band: 0 low, 1 middle, 2 high |
| m_o | output | 8 | M divider field |
| a_o | output | 8 | A divider field |
| r_o | output | 8 | R divider field |
| valid_o | output | 1 | One-cycle pulse after an accepted frame |
| err_o | output | 1 | One-cycle pulse after a rejected frame |

## Verification
There is one register stage between the marker write and every result. The settings, valid_o and err_o all appear in the cycle after the clock edge that accepts the marker write. The bench drives inputs on the falling edge, and after the final write it samples all outputs at the next falling edge. It samples once more one cycle later to confirm that the strobes have dropped and the settings have held. Expected settings come from an arithmetic sweep of M across the legal boundary, with the post-divider code, band code, A, R and the filler bits each derived from the sweep index.

// File: rtl/synth_load_pkg.sv
package synth_load_pkg;
  localparam int FIELD_W  = 8;
  localparam int FRAME_W  = 56;
  localparam int POS_PD   = 12;
  localparam int POS_BAND = 24;
  localparam int POS_M    = 32;
  localparam int POS_A    = 40;
  localparam int POS_R    = 48;

  typedef enum logic [1:0] {
    BAND_LOW  = 2'd0,
    BAND_MID  = 2'd1,
    BAND_HIGH = 2'd2
  } band_e;

  typedef struct packed {
    logic [1:0]         pd_log2;
    band_e              band;
    logic [FIELD_W-1:0] m;
    logic [FIELD_W-1:0] a;
    logic [FIELD_W-1:0] r;
  } synth_cfg_t;
endpackage

// File: rtl/sl_shifter.sv
module sl_shifter #(
  parameter int FRAME_W = synth_load_pkg::FRAME_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               shift_en_i,
  input  logic               bit_i,
  output logic [FRAME_W-1:0] frame_o
);
  logic [FRAME_W-2:0] sr_q;

  // newest bit sits at index 0 of the frame view
  assign frame_o = {sr_q, bit_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         sr_q <= '0;
    else if (shift_en_i) sr_q <= frame_o[FRAME_W-2:0];
  end

  // R2
  hold_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_en_i |=> $stable(sr_q));
endmodule

// File: rtl/sl_unpack.sv
module sl_unpack
  import synth_load_pkg::*;
#(
  parameter int FRAME_W  = synth_load_pkg::FRAME_W,
  parameter int POS_PD   = synth_load_pkg::POS_PD,
  parameter int POS_BAND = synth_load_pkg::POS_BAND,
  parameter int POS_M    = synth_load_pkg::POS_M,
  parameter int POS_A    = synth_load_pkg::POS_A,
  parameter int POS_R    = synth_load_pkg::POS_R,
  parameter int M_MAX    = 63
) (
  input  logic [FRAME_W-1:0] frame_i,
  output synth_cfg_t         cfg_o,
  output logic               m_ovf_o
);
  logic [FIELD_W-1:0] m_raw, a_raw, r_raw;
  logic [1:0]         pd_code, band_code;

  // arrival index k lives at frame_i[FRAME_W-1-k]
  for (genvar j = 0; j < FIELD_W; j++) begin : g_fld
    assign m_raw[j] = frame_i[FRAME_W-1-POS_M-j];
    assign a_raw[j] = frame_i[FRAME_W-1-POS_A-j];
    assign r_raw[j] = frame_i[FRAME_W-1-POS_R-j];
  end
  for (genvar j = 0; j < 2; j++) begin : g_sel
    assign pd_code[j]   = frame_i[FRAME_W-1-POS_PD-j];
    assign band_code[j] = frame_i[FRAME_W-1-POS_BAND-j];
  end

  always_comb begin
    cfg_o.pd_log2 = pd_code[1] ? 2'd2 : pd_code;
    unique case (band_code)
      2'b00:   cfg_o.band = BAND_LOW;
      2'b01:   cfg_o.band = BAND_MID;
      default: cfg_o.band = BAND_HIGH;
    endcase
    cfg_o.m = m_raw;
    cfg_o.a = a_raw;
    cfg_o.r = r_raw;
  end

  assign m_ovf_o = (int'(m_raw) > M_MAX);
endmodule

// File: rtl/sl_latch.sv
module sl_latch
  import synth_load_pkg::*;
#(
  parameter int M_MAX = 63,
  parameter int M_RST = 34,
  parameter int A_RST = 1,
  parameter int R_RST = 29
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       load_i,
  input  synth_cfg_t cfg_i,
  input  logic       ovf_i,
  output synth_cfg_t cfg_o,
  output logic       valid_o,
  output logic       err_o
);
  localparam synth_cfg_t CFG_RST = '{
    pd_log2: 2'd0,
    band:    BAND_LOW,
    m:       FIELD_W'(M_RST),
    a:       FIELD_W'(A_RST),
    r:       FIELD_W'(R_RST)
  };

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_o   <= CFG_RST;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= load_i && !ovf_i;
      err_o   <= load_i && ovf_i;
      if (load_i && !ovf_i) cfg_o <= cfg_i;
    end
  end

  // R8
  valid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(load_i) && !$past(ovf_i));
  // R8
  no_silent_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(cfg_o));
  // R7
  err_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));
  // R7
  m_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cfg_o.m) <= M_MAX);
endmodule

// File: rtl/synth_serial_loader.sv
module synth_serial_loader
  import synth_load_pkg::*;
#(
  parameter int M_MAX = 63,
  parameter int M_RST = 34,
  parameter int A_RST = 1,
  parameter int R_RST = 29
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_data_i,
  output logic [1:0]         post_div_o,
  output logic [1:0]         band_o,
  output logic [FIELD_W-1:0] m_o,
  output logic [FIELD_W-1:0] a_o,
  output logic [FIELD_W-1:0] r_o,
  output logic               valid_o,
  output logic               err_o
);
  logic [FRAME_W-1:0] frame;
  synth_cfg_t         dec_cfg, cur_cfg;
  logic               m_ovf, load;

  assign load = wr_en_i && wr_data_i[1];

  sl_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .shift_en_i (wr_en_i),
    .bit_i      (wr_data_i[0]),
    .frame_o    (frame)
  );

  sl_unpack #(
    .FRAME_W (FRAME_W),
    .POS_PD  (POS_PD),
    .POS_BAND(POS_BAND),
    .POS_M   (POS_M),
    .POS_A   (POS_A),
    .POS_R   (POS_R),
    .M_MAX   (M_MAX)
  ) u_unpack (
    .frame_i (frame),
    .cfg_o   (dec_cfg),
    .m_ovf_o (m_ovf)
  );

  sl_latch #(
    .M_MAX(M_MAX), .M_RST(M_RST), .A_RST(A_RST), .R_RST(R_RST)
  ) u_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load),
    .cfg_i   (dec_cfg),
    .ovf_i   (m_ovf),
    .cfg_o   (cur_cfg),
    .valid_o (valid_o),
    .err_o   (err_o)
  );

  assign post_div_o = cur_cfg.pd_log2;
  assign band_o     = cur_cfg.band;
  assign m_o        = cur_cfg.m;
  assign a_o        = cur_cfg.a;
  assign r_o        = cur_cfg.r;

  // R6
  band_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    band_o != 2'b11);
  // R5
  pd_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_div_o != 2'b11);
  // R2
  idle_no_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> !valid_o && !err_o);
endmodule

// File: tb/synth_serial_loader_bench.sv
module synth_serial_loader_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] wr_data = 2'b00;
  logic [1:0] post_div, band;
  logic [7:0] m_val, a_val, r_val;
  logic       valid, err;

  int checks = 0;
  int errors = 0;
  int exp_pd, exp_band, exp_m, exp_a, exp_r;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_serial_loader u_synth_serial_loader (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .post_div_o(post_div), .band_o(band), .m_o(m_val), .a_o(a_val),
    .r_o(r_val), .valid_o(valid), .err_o(err)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_settings(string req);
    chk({req, " post_div"}, int'(post_div), exp_pd);
    chk({req, " band"}, int'(band), exp_band);
    chk({req, " m"}, int'(m_val), exp_m);
    chk({req, " a"}, int'(a_val), exp_a);
    chk({req, " r"}, int'(r_val), exp_r);
  endtask

  task automatic put(logic b, logic mk);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = {mk, b};
  endtask

  task automatic idle(logic [1:0] junk);
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = junk;
  endtask

  function automatic logic frame_bit(int i, int pdc, int bc, int m, int a, int r,
                                     logic [55:0] fill);
    if (i >= 12 && i < 14) return 1'((pdc >> (i - 12)) & 1);
    if (i >= 24 && i < 26) return 1'((bc >> (i - 24)) & 1);
    if (i >= 32 && i < 40) return 1'((m >> (i - 32)) & 1);
    if (i >= 40 && i < 48) return 1'((a >> (i - 40)) & 1);
    if (i >= 48)           return 1'((r >> (i - 48)) & 1);
    return fill[i];
  endfunction

  // R3 R4: full 56-bit frame, marker on the last write; optional idle gaps
  task automatic send_frame(int pdc, int bc, int m, int a, int r,
                            logic [55:0] fill, bit gaps);
    for (int i = 0; i < 56; i++) begin
      put(frame_bit(i, pdc, bc, m, a, r, fill), i == 55);
      if (gaps && i < 55) idle(2'b11);
    end
    idle(2'b00);
  endtask

  // result due one edge after the marker write: sample now, then one cycle later
  task automatic expect_result(string req, int pdc, int bc, int m, int a, int r);
    if (m > 63) begin
      chk({req, " R7 err"}, int'(err), 1);
      chk({req, " R7 valid"}, int'(valid), 0);
    end else begin
      exp_pd   = (pdc >= 2) ? 2 : pdc;
      exp_band = (bc == 0) ? 0 : (bc == 1) ? 1 : 2;
      exp_m = m; exp_a = a; exp_r = r;
      chk({req, " R8 valid"}, int'(valid), 1);
      chk({req, " R7 err"}, int'(err), 0);
    end
    chk_settings(req);
    @(negedge clk);
    chk({req, " R8 valid drop"}, int'(valid), 0);
    chk({req, " R7 err drop"}, int'(err), 0);
    chk_settings({req, " R8 hold"});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    exp_pd = 0; exp_band = 0; exp_m = 34; exp_a = 1; exp_r = 29;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 valid", int'(valid), 0);
    chk("R1 err", int'(err), 0);
    chk_settings("R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R3 R4 R5 R6 R7: sweep M across the legal boundary
    for (int k = 0; k < 80; k++) begin
      int pdc = k % 4;
      int bc  = (k / 4) % 4;
      int a   = (k * 37 + 1) % 256;
      int r   = 255 - k * 3;
      logic [55:0] fill = 56'h5A3C9F0E1B2D47 ^ (56'(k) * 56'h1000193);
      send_frame(pdc, bc, k, a, r, fill, 1'b0);
      expect_result("R3 sweep", pdc, bc, k, a, r);
    end

    // R7: M at the top of the field
    send_frame(3, 3, 255, 9, 9, 56'hFFFFFFFFFFFFFF, 1'b0);
    expect_result("R7 m255", 3, 3, 255, 9, 9);
    send_frame(1, 1, 64, 200, 100, 56'h0, 1'b0);
    expect_result("R7 m64", 1, 1, 64, 200, 100);
    send_frame(2, 2, 63, 128, 1, 56'h0, 1'b0);
    expect_result("R7 m63", 2, 2, 63, 128, 1);

    // R2: idle cycles with junk inside a frame, marker junk while idle
    send_frame(1, 1, 17, 85, 170, 56'h123456789ABCDE, 1'b1);
    expect_result("R2 gaps", 1, 1, 17, 85, 170);
    repeat (4) idle(2'b11);
    chk("R2 idle marker valid", int'(valid), 0);
    chk("R2 idle marker err", int'(err), 0);
    chk_settings("R2 idle");

    // R9: long run of older bits before the frame
    for (int i = 0; i < 37; i++) put(1'(i % 3 == 0), 1'b0);
    send_frame(0, 2, 5, 6, 7, 56'hA5A5A5A5A5A5A5, 1'b0);
    expect_result("R9 prefix", 0, 2, 5, 6, 7);

    // R10: reset clears the history; short frame of 24 bits
    rst_n = 1'b0;
    @(negedge clk);
    exp_pd = 0; exp_band = 0; exp_m = 34; exp_a = 1; exp_r = 29;
    chk_settings("R1 re-reset");
    rst_n = 1'b1;
    for (int i = 32; i < 56; i++)
      put(frame_bit(i, 0, 0, 45, 99, 201, 56'h0), i == 55);
    idle(2'b00);
    expect_result("R10 short", 0, 0, 45, 99, 201);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule